// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block arbitrates between the left and right ports of a shared word memory. It works in a single clock domain. Each port presents an enable, a write strobe and a word address every cycle. If both ports are enabled on the same word in the same cycle, one port keeps the word and the other port is flagged busy. The memory array writes only through the per-port write qualifiers this block produces, so a busy port cannot change the word. A busy port's read still returns data, but its busy flag stays low while the collision lasts.

A port that already held a word in the previous cycle wins against a port that has just moved onto that word. If both ports arrive in the same cycle, a fixed tie-break decides, and the left port wins by default. Once a winner is chosen, it keeps the word for as long as the collision continues without a break.

A mode pin selects master or slave operation. In master mode the block drives busy from its own arbitration. In slave mode the busy flags come from a master arbiter, and those external flags also block writes. Several arbiters can therefore share one decision when memories are placed side by side for wider words. The interface has only plain control and status pins. There is no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `dpa_arbiter`

## Requirements
- R1: In master mode, when the ports are not both enabled on the same address, both busy flags read 1 (inactive).
- R2: In master mode, when both ports are enabled on the same address, exactly one busy flag reads 0 (active low). The other port proceeds.
- R3: When one port was enabled on an address in the previous cycle and the other port joins that address, the port that was already there wins.
- R4: When both ports arrive on a common address in the same cycle with no prior holder, the left port wins (tie-break parameter default).
- R5: While a collision continues in consecutive cycles, the winner does not change.
- R6: Busy is released in the same cycle that the addresses differ or either enable drops.
- R7: A port's write qualifier is 1 exactly when its enable is 1, its write strobe is 1 and its busy flag is 1 (inactive). A busy port's write is suppressed.
- R8: In slave mode, each busy output equals the matching external busy input, regardless of any local collision.
- R9: In slave mode, an external busy input of 0 suppresses that port's write qualifier.
- R10: After reset with both ports idle, both busy flags are 1 and both write qualifiers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_master | input | 1 | 1 = arbitrate locally, 0 = take busy from external inputs |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | External busy for the left port (slave mode), active low |
| r_busy_in_n | input | 1 | External busy for the right port (slave mode), active low |
| l_busy_n | output | 1 | Effective left busy, active low |
| r_busy_n | output | 1 | Effective right busy, active low |
| l_wr_en | output | 1 | Qualified left write to the array |
| r_wr_en | output | 1 | Qualified right write to the array |

## Verification
Two functions can fall in the same cycle. The first is the choice of a winner: incumbency, the tie-break and holding an ongoing win. The second is write qualification. They coincide whenever both ports write to one word in one cycle. The bench provokes this with directed same-cycle arrivals and with late joins, and then runs a long random run over a four-word address range so that collisions, moves and releases overlap. A behavioural model, which keeps its own record of the previous enables, addresses and holder, predicts both busy flags and both write qualifiers every clock. Every cycle those four values are compared against the outputs.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned SIDES = 2;
  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
endpackage

// File: rtl/dpa_port_track.sv
// Remembers last cycle's enable and address of one port and flags
// whether the port is still sitting on the same word (incumbency).
module dpa_port_track #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              incumbent
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce;
      addr_q <= addr;
    end
  end

  assign incumbent = ce & ce_q & (addr == addr_q);
endmodule

// File: rtl/dpa_grant.sv
// Chooses the collision winner: held owner first, then incumbency,
// then the fixed tie-break. The owner is kept while the collision lasts.
module dpa_grant
  import dpa_pkg::*;
#(
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   match,
  input  logic   inc_l,
  input  logic   inc_r,
  output owner_e winner
);
  localparam owner_e TIE_OWNER = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;

  owner_e owner_q;
  owner_e owner_d;

  always_comb begin
    if (owner_q != OWN_NONE)   winner = owner_q;
    else if (inc_r && !inc_l)  winner = OWN_RIGHT;
    else if (inc_l && !inc_r)  winner = OWN_LEFT;
    else                       winner = TIE_OWNER;
    owner_d = match ? winner : OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end
endmodule

// File: rtl/dpa_busy_gate.sv
// Selects the effective busy for one port and qualifies its write.
module dpa_busy_gate (
  input  logic mode_master,
  input  logic lose,
  input  logic ext_busy_n,
  input  logic ce,
  input  logic we,
  output logic busy_n,
  output logic wr_en
);
  always_comb begin
    busy_n = mode_master ? ~lose : ext_busy_n;
    wr_en  = ce & we & busy_n;
  end
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter bit          TIE_LEFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_master,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);
  logic [SIDES-1:0]             ce_v, we_v, ext_v, inc_v, lose_v, busy_v, wren_v;
  logic [SIDES-1:0][ADDR_W-1:0] addr_v;
  logic                         match;
  owner_e                       winner;

  assign ce_v   = {r_ce, l_ce};
  assign we_v   = {r_we, l_we};
  assign ext_v  = {r_busy_in_n, l_busy_in_n};
  assign addr_v = {r_addr, l_addr};

  assign match = l_ce & r_ce & (l_addr == r_addr);

  generate
    for (genvar g = 0; g < SIDES; g++) begin : g_track
      dpa_port_track #(.ADDR_W(ADDR_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce_v[g]),
        .addr      (addr_v[g]),
        .incumbent (inc_v[g])
      );
    end
  endgenerate

  dpa_grant #(.TIE_LEFT(TIE_LEFT)) u_grant (
    .clk    (clk),
    .rst_n  (rst_n),
    .match  (match),
    .inc_l  (inc_v[SIDE_L]),
    .inc_r  (inc_v[SIDE_R]),
    .winner (winner)
  );

  assign lose_v[SIDE_L] = match & (winner == OWN_RIGHT);
  assign lose_v[SIDE_R] = match & (winner == OWN_LEFT);

  generate
    for (genvar g = 0; g < SIDES; g++) begin : g_gate
      dpa_busy_gate u_gate (
        .mode_master (mode_master),
        .lose        (lose_v[g]),
        .ext_busy_n  (ext_v[g]),
        .ce          (ce_v[g]),
        .we          (we_v[g]),
        .busy_n      (busy_v[g]),
        .wr_en       (wren_v[g])
      );
    end
  endgenerate

  assign l_busy_n = busy_v[SIDE_L];
  assign r_busy_n = busy_v[SIDE_R];
  assign l_wr_en  = wren_v[SIDE_L];
  assign r_wr_en  = wren_v[SIDE_R];
endmodule

// File: rtl/dpa_arbiter_chk.sv
module dpa_arbiter_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_master,
  input logic              l_ce,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_ce,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_en,
  input logic              r_wr_en
);
  logic same_word;
  assign same_word = l_ce && r_ce && (l_addr == r_addr);

  a_r1_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && !same_word) |-> (l_busy_n && r_busy_n));

  a_r2_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && same_word) |-> ($countones({l_busy_n, r_busy_n}) == 1));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && $past(mode_master) && same_word && $past(same_word))
      |-> (l_busy_n == $past(l_busy_n)));

  a_r7_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n |-> !l_wr_en) and (!r_busy_n |-> !r_wr_en));

  a_r8_slave_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_master |-> (l_busy_n == l_busy_in_n && r_busy_n == r_busy_in_n));
endmodule

bind dpa_arbiter dpa_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_master (mode_master),
  .l_ce        (l_ce),
  .l_we        (l_we),
  .l_addr      (l_addr),
  .r_ce        (r_ce),
  .r_we        (r_we),
  .r_addr      (r_addr),
  .l_busy_in_n (l_busy_in_n),
  .r_busy_in_n (r_busy_in_n),
  .l_busy_n    (l_busy_n),
  .r_busy_n    (r_busy_n),
  .l_wr_en     (l_wr_en),
  .r_wr_en     (r_wr_en)
);

// File: tb/dpa_arbiter_tb_top.sv
module dpa_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_master = 1'b1;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1, r_busy_in_n = 1;
  logic l_busy_n, r_busy_n, l_wr_en, r_wr_en;

  int n_checks = 0;
  int n_errors = 0;

  // behavioural reference state
  bit m_pce_l = 0, m_pce_r = 0;
  int m_pa_l = 0, m_pa_r = 0;
  int m_own = 0; // 0 none, 1 left, 2 right

  always #(CLK_PERIOD/2) clk = ~clk;

  dpa_arbiter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  task automatic check1(input string req, input string what, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit mm, input bit cl, input bit wl, input int al,
                     input bit cr, input bit wr, input int ar,
                     input bit exl, input bit exr, input string req);
    bit match, inc_l, inc_r, bl, br;
    int win;
    @(negedge clk);
    mode_master = mm; l_ce = cl; l_we = wl; l_addr = AW'(al);
    r_ce = cr; r_we = wr; r_addr = AW'(ar);
    l_busy_in_n = exl; r_busy_in_n = exr;
    #1;
    match = cl && cr && (al == ar);
    inc_l = cl && m_pce_l && (al == m_pa_l);
    inc_r = cr && m_pce_r && (ar == m_pa_r);
    if (m_own != 0)          win = m_own;
    else if (inc_r && !inc_l) win = 2;
    else                      win = 1;
    if (mm) begin
      bl = !(match && win == 2);
      br = !(match && win == 1);
    end else begin
      bl = exl;
      br = exr;
    end
    check1(req, "l_busy_n", l_busy_n, bl);
    check1(req, "r_busy_n", r_busy_n, br);
    check1(req, "l_wr_en", l_wr_en, cl && wl && bl);
    check1(req, "r_wr_en", r_wr_en, cr && wr && br);
    m_own = match ? win : 0;
    m_pce_l = cl; m_pa_l = al;
    m_pce_r = cr; m_pa_r = ar;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state, idle
    cyc(1, 0,0,0, 0,0,0, 1,1, "R10");
    // R1 different addresses, both write
    cyc(1, 1,1,3, 1,1,4, 1,1, "R1");
    cyc(1, 0,0,0, 0,0,0, 1,1, "R1");
    // R4 same-cycle arrival, left wins; R7 right write suppressed
    cyc(1, 1,1,9, 1,1,9, 1,1, "R4");
    // R5 collision held
    cyc(1, 1,0,9, 1,1,9, 1,1, "R5");
    cyc(1, 1,1,9, 1,1,9, 1,1, "R7");
    // R6 right moves away
    cyc(1, 1,1,9, 1,1,10, 1,1, "R6");
    // R3 right incumbent on 10, left joins
    cyc(1, 1,1,10, 1,1,10, 1,1, "R3");
    cyc(1, 1,1,10, 1,0,10, 1,1, "R5");
    // R6 right enable drops
    cyc(1, 1,1,10, 0,0,10, 1,1, "R6");
    // R3 left incumbent on 10, right joins
    cyc(1, 1,0,10, 1,1,10, 1,1, "R3");
    cyc(1, 0,0,0, 0,0,0, 1,1, "R6");
    // R8 slave: collision ignored, external busy followed
    cyc(0, 1,0,7, 1,0,7, 1,1, "R8");
    cyc(0, 1,0,7, 1,0,7, 0,1, "R8");
    cyc(0, 1,0,2, 1,0,5, 1,0, "R8");
    // R9 slave: external busy suppresses writes
    cyc(0, 1,1,2, 1,1,5, 0,1, "R9");
    cyc(0, 1,1,2, 1,1,5, 1,0, "R9");
    cyc(0, 1,1,2, 1,1,2, 1,1, "R9");
    cyc(1, 0,0,0, 0,0,0, 1,1, "R10");
    // R2 random mix over a small address range
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 8) != 0,
          $urandom % 4 != 0, $urandom % 2 == 1, int'($urandom % 4),
          $urandom % 4 != 0, $urandom % 2 == 1, int'($urandom % 4),
          $urandom % 3 != 0, $urandom % 3 != 0, "R2");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule